// File: doc/BRIEF.md
# TCP Send Segmentation Controller

This block takes one send command and turns it into an ordered series of TCP payload segment requests for a downstream header builder. Software supplies a total byte count and a per-segment byte count. The block slices the transfer into full-size segments and, when the total does not divide evenly, one short tail segment at the end. Each request carries a byte offset within the command and a byte length.

Two kinds of credit pace the issue. The first is the amount of data the transmit buffer holds. The second is the peer's advertised receive window, less the bytes already in flight. The short tail is held back until every full segment before it has been acknowledged. By default the tail is then sent a second time, which prompts the peer to acknowledge quickly. While a command runs, the outstanding total can be extended, so a long stream continues without a new command. The busy flag falls only when an acknowledgement covers the last byte.

Top module: `seg_send_ctrl`

## Requirements
- R1: The total, segment and extension lengths count bytes, and their six least significant bits are ignored (treated as zero).
- R2: A start strobe is accepted only when the block is idle, the aligned total is at least 64, and the aligned segment length lies in 64..8960. In every other case the strobe has no effect, and a strobe that arrives while busy leaves the running command untouched.
- R3: When the total is an exact multiple of the segment length, the block issues total/segment-length requests at offsets 0, L, 2L, … in ascending order. Each request has length L and is issued exactly once.
- R4: When a short tail remains, every full segment is issued first. The tail request (offset = total minus tail, length = tail) is issued only after the acknowledged offset equals that tail offset.
- R5: With `no_dup` = 0 on the start cycle, the tail request is issued twice, on consecutive cycles. With `no_dup` = 1, it is issued once.
- R6: `busy` rises on an accepted start. It falls only after every request has been issued and the acknowledged offset equals the total.
- R7: `remain_len` equals the total minus the offset of the next byte not yet requested. It reads 0 once all bytes have been requested.
- R8: An `ext_wr` pulse while busy adds the aligned `ext_len` to the total, saturating at 0xFFFFFFC0. An `ext_wr` pulse while idle has no effect.
- R9: A new request is issued only if `buf_words`×64 is at least the bytes in flight (next offset minus acknowledged offset) plus the request length.
- R10: A new request is issued only if `peer_win` is at least the bytes in flight plus the request length.
- R11: An acknowledgement is taken only if its offset lies between the current acknowledged offset and the next offset, inclusive. Any other acknowledgement has no effect.
- R12: After reset, `busy`, `seg_req` and `remain_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command start strobe |
| total_len | input | 32 | Total bytes for the command |
| pkt_len | input | 16 | Bytes per full segment |
| no_dup | input | 1 | 1 = send the tail segment once |
| ext_wr | input | 1 | Extension write strobe |
| ext_len | input | 32 | Bytes to add to the running total |
| ack_vld | input | 1 | Acknowledgement strobe |
| ack_ofs | input | 32 | Acknowledged byte offset within the command |
| buf_words | input | 16 | 64-byte words held from the acknowledged offset onward |
| peer_win | input | 32 | Peer receive window in bytes |
| seg_req | output | 1 | One-cycle segment request |
| seg_ofs | output | 32 | Request byte offset |
| seg_len | output | 16 | Request byte length |
| busy | output | 1 | Command in progress |
| remain_len | output | 32 | Bytes not yet requested |

## Verification
The bench uses the default parameters: a 16-bit buffer word count, 16-bit segment lengths and an 8960-byte maximum segment. With these values, a buffer credit of several megabytes can be offered or cut to zero, and the largest legal segment, a total near 0xFFFFFFC0, and extension saturation can all be reached. A scoreboard compares each request's offset and length against queued expectations. Because of this, any segment issued too early, twice or out of order is reported as an unexpected or mismatched item. Windows of starved buffer credit, narrow peer window and out-of-range acknowledgements show that the gating holds.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned LEN_W = 32;
  localparam logic [LEN_W-1:0] LEN_CAP = 32'hFFFF_FFC0;

  function automatic logic [LEN_W-1:0] align64(input logic [LEN_W-1:0] v);
    return v & LEN_CAP;
  endfunction

  function automatic logic [LEN_W-1:0] sat_add(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    logic [LEN_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, LEN_CAP}) ? LEN_CAP : s[LEN_W-1:0];
  endfunction

  function automatic logic fits(input logic [LEN_W:0]   cap,
                                input logic [LEN_W-1:0] inflight,
                                input logic [LEN_W-1:0] len);
    return cap >= ({1'b0, inflight} + {1'b0, len});
  endfunction
endpackage

// File: rtl/seg_cmd_chk.sv
module seg_cmd_chk
  import seg_pkg::*;
#(
  parameter int unsigned PKT_W   = 16,
  parameter int unsigned PKT_MIN = 64,
  parameter int unsigned PKT_MAX = 8960
) (
  input  logic [LEN_W-1:0] total_len,
  input  logic [PKT_W-1:0] pkt_len,
  output logic [LEN_W-1:0] tot_a,
  output logic [PKT_W-1:0] pkl_a,
  output logic             cmd_ok
);
  localparam logic [PKT_W-1:0] PKT_MASK = ~PKT_W'(63);

  always_comb begin
    tot_a  = align64(total_len);
    pkl_a  = pkt_len & PKT_MASK;
    cmd_ok = (tot_a != '0) &&
             (LEN_W'(pkl_a) >= LEN_W'(PKT_MIN)) &&
             (LEN_W'(pkl_a) <= LEN_W'(PKT_MAX));
  end
endmodule

// File: rtl/seg_credit.sv
module seg_credit
  import seg_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] buf_words,
  input  logic [LEN_W-1:0]  peer_win,
  input  logic [LEN_W-1:0]  nxt_ofs,
  input  logic [LEN_W-1:0]  ack_ofs,
  input  logic [LEN_W-1:0]  len,
  output logic              ok_data,
  output logic              ok_win
);
  localparam int unsigned PAD = LEN_W + 1 - WORD_W - 6;

  logic [LEN_W:0]   cap_buf;
  logic [LEN_W-1:0] inflight;

  always_comb begin
    cap_buf  = {{PAD{1'b0}}, buf_words, 6'b0};
    inflight = nxt_ofs - ack_ofs;
    ok_data  = fits(cap_buf, inflight, len);
    ok_win   = fits({1'b0, peer_win}, inflight, len);
  end
endmodule

// File: rtl/seg_ack_trk.sv
module seg_ack_trk
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             busy,
  input  logic             ack_vld,
  input  logic [LEN_W-1:0] ack_ofs,
  input  logic [LEN_W-1:0] nxt_ofs,
  output logic [LEN_W-1:0] ack_q,
  output logic             ack_take
);
  assign ack_take = busy && ack_vld && (ack_ofs >= ack_q) && (ack_ofs <= nxt_ofs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ack_q <= '0;
    else if (clear)    ack_q <= '0;
    else if (ack_take) ack_q <= ack_ofs;
  end

  // R11: acknowledged pointer never passes the issue pointer
  p_ack_le_nxt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ack_q <= nxt_ofs);
  // R11: acknowledged pointer never moves backwards within a command
  p_ack_nodec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> ack_q >= $past(ack_q));
endmodule

// File: rtl/seg_send_ctrl.sv
module seg_send_ctrl
  import seg_pkg::*;
#(
  parameter int unsigned PKT_W   = 16,
  parameter int unsigned PKT_MAX = 8960,
  parameter int unsigned WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       total_len,
  input  logic [PKT_W-1:0]  pkt_len,
  input  logic              no_dup,
  input  logic              ext_wr,
  input  logic [31:0]       ext_len,
  input  logic              ack_vld,
  input  logic [31:0]       ack_ofs,
  input  logic [WORD_W-1:0] buf_words,
  input  logic [31:0]       peer_win,
  output logic              seg_req,
  output logic [31:0]       seg_ofs,
  output logic [PKT_W-1:0]  seg_len,
  output logic              busy,
  output logic [31:0]       remain_len
);
  logic             busy_q, nodup_q, dup_pend_q;
  logic [LEN_W-1:0] tot_q, nxt_q, res_ofs_q, seg_ofs_q;
  logic [PKT_W-1:0] pkl_q, res_len_q, seg_len_q;
  logic             seg_req_q, seg_dup_q;

  logic [LEN_W-1:0] tot_a, ext_a, ack_q, rem, pkl32, cand_len;
  logic [PKT_W-1:0] pkl_a;
  logic             cmd_ok, ack_take, ok_data, ok_win;
  logic             full_avail, is_res, res_gate;
  logic             start_acc, ext_take, issue_new, issue_dup, done;

  seg_cmd_chk #(.PKT_W(PKT_W), .PKT_MIN(64), .PKT_MAX(PKT_MAX)) u_chk (
    .total_len(total_len), .pkt_len(pkt_len),
    .tot_a(tot_a), .pkl_a(pkl_a), .cmd_ok(cmd_ok));

  seg_ack_trk u_ack (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .busy(busy_q),
    .ack_vld(ack_vld), .ack_ofs(ack_ofs), .nxt_ofs(nxt_q),
    .ack_q(ack_q), .ack_take(ack_take));

  seg_credit #(.WORD_W(WORD_W)) u_cred (
    .buf_words(buf_words), .peer_win(peer_win), .nxt_ofs(nxt_q),
    .ack_ofs(ack_q), .len(cand_len), .ok_data(ok_data), .ok_win(ok_win));

  always_comb begin
    ext_a      = align64(ext_len);
    rem        = tot_q - nxt_q;
    pkl32      = LEN_W'(pkl_q);
    full_avail = rem >= pkl32;
    cand_len   = full_avail ? pkl32 : rem;
    is_res     = !full_avail && (rem != '0);
    res_gate   = !is_res || (ack_q == nxt_q);
    start_acc  = start && !busy_q && cmd_ok;
    ext_take   = ext_wr && busy_q;
    issue_dup  = busy_q && dup_pend_q;
    issue_new  = busy_q && !dup_pend_q && (rem != '0) && res_gate && ok_data && ok_win;
    done       = busy_q && !dup_pend_q && (rem == '0) && (ack_q == tot_q) &&
                 !(ext_take && ext_a != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; nodup_q <= 1'b0; dup_pend_q <= 1'b0;
      tot_q <= '0; nxt_q <= '0; pkl_q <= '0;
      res_ofs_q <= '0; res_len_q <= '0;
      seg_req_q <= 1'b0; seg_ofs_q <= '0; seg_len_q <= '0; seg_dup_q <= 1'b0;
    end else begin
      seg_req_q <= issue_new || issue_dup;
      if (start_acc) begin
        busy_q     <= 1'b1;
        tot_q      <= tot_a;
        nxt_q      <= '0;
        pkl_q      <= pkl_a;
        nodup_q    <= no_dup;
        dup_pend_q <= 1'b0;
      end else begin
        if (ext_take) tot_q <= sat_add(tot_q, ext_a);
        if (done)     busy_q <= 1'b0;
        if (issue_dup) begin
          seg_ofs_q  <= res_ofs_q;
          seg_len_q  <= res_len_q;
          seg_dup_q  <= 1'b1;
          dup_pend_q <= 1'b0;
        end else if (issue_new) begin
          seg_ofs_q <= nxt_q;
          seg_len_q <= cand_len[PKT_W-1:0];
          seg_dup_q <= 1'b0;
          nxt_q     <= nxt_q + cand_len;
          if (is_res && !nodup_q) begin
            dup_pend_q <= 1'b1;
            res_ofs_q  <= nxt_q;
            res_len_q  <= cand_len[PKT_W-1:0];
          end
        end
      end
    end
  end

  assign seg_req    = seg_req_q;
  assign seg_ofs    = seg_ofs_q;
  assign seg_len    = seg_len_q;
  assign busy       = busy_q;
  assign remain_len = tot_q - nxt_q;

  // R6: requests only appear during a command
  p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req_q |-> busy_q);
  // R6: busy falls only once the acknowledged offset reached the total
  p_done_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(ack_q) == $past(tot_q));
  // R4: a first-time short tail waits for all prior bytes to be acknowledged
  p_res_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req_q && !seg_dup_q && (seg_len_q < pkl_q) |-> $past(ack_q) == seg_ofs_q);
  // R5: a duplicate follows its original tail on the next cycle
  p_dup_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req_q && seg_dup_q |->
      $past(seg_req_q) && !$past(seg_dup_q) && $past(seg_ofs_q) == seg_ofs_q);
  // R9: buffer held enough data for the new request
  p_credit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req_q && !seg_dup_q |->
      (33'($past(buf_words)) << 6) + 33'($past(ack_q)) >= 33'(seg_ofs_q) + 33'(seg_len_q));
  // R10: peer window admitted the new request
  p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_req_q && !seg_dup_q |->
      33'($past(peer_win)) + 33'($past(ack_q)) >= 33'(seg_ofs_q) + 33'(seg_len_q));
endmodule

// File: tb/sim_seg_send_ctrl.sv
`timescale 1ns/1ps
module sim_seg_send_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, no_dup = 1'b0, ext_wr = 1'b0, ack_vld = 1'b0;
  logic [31:0] total_len = '0, ext_len = '0, ack_ofs = '0;
  logic [31:0] peer_win = 32'hFFFF_FFFF;
  logic [15:0] pkt_len = '0, buf_words = 16'hFFFF;
  logic        seg_req, busy;
  logic [31:0] seg_ofs, remain_len;
  logic [15:0] seg_len;

  int checks = 0, errors = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  seg_send_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .pkt_len(pkt_len), .no_dup(no_dup), .ext_wr(ext_wr), .ext_len(ext_len),
    .ack_vld(ack_vld), .ack_ofs(ack_ofs), .buf_words(buf_words),
    .peer_win(peer_win), .seg_req(seg_req), .seg_ofs(seg_ofs),
    .seg_len(seg_len), .busy(busy), .remain_len(remain_len));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_seg(input logic [31:0] o, input logic [15:0] l, input string req);
    exp_q.push_back({o, l});
    tag_q.push_back(req);
  endtask

  task automatic start_cmd(input logic [31:0] t, input logic [15:0] p, input logic nd);
    @(negedge clk);
    start = 1'b1; total_len = t; pkt_len = p; no_dup = nd;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_ack(input logic [31:0] v);
    @(negedge clk);
    ack_vld = 1'b1; ack_ofs = v;
    @(negedge clk);
    ack_vld = 1'b0;
  endtask

  task automatic send_ext(input logic [31:0] v);
    @(negedge clk);
    ext_wr = 1'b1; ext_len = v;
    @(negedge clk);
    ext_wr = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 300) begin
      @(negedge clk); #1;
      n++;
    end
    chk({req, " pending expected segments"}, 64'(exp_q.size()), 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && seg_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R4/R5 unexpected segment actual=%0h/%0h expected=none", seg_ofs, seg_len);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({seg_ofs, seg_len} !== e) begin
          errors++;
          $display("FAIL %s segment actual=%0h/%0h expected=%0h/%0h",
                   t, seg_ofs, seg_len, e[47:16], e[15:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R12 reset state
    chk("R12 busy", 64'(busy), 0);
    chk("R12 seg_req", 64'(seg_req), 0);
    chk("R12 remain", 64'(remain_len), 0);
    rst_n = 1'b1;
    tick(2);

    // R3 + R1: exact multiple, unaligned low bits ignored
    for (int i = 0; i < 4; i++) expect_seg(32'(i * 1024), 16'd1024, "R3");
    start_cmd(32'd4096 + 5, 16'd1024 + 3, 1'b0);
    wait_drain("R3");
    chk("R7 remain after all issued", 64'(remain_len), 0);
    tick(5);
    chk("R6 busy before final ack", 64'(busy), 1);
    send_ack(32'd4096);
    tick(1);
    chk("R6 busy after final ack", 64'(busy), 0);

    // R4 + R5: residue held, then duplicated
    expect_seg(0, 1024, "R4"); expect_seg(1024, 1024, "R4");
    start_cmd(32'd2240, 16'd1024, 1'b0);
    wait_drain("R4");
    tick(5);
    chk("R7 remain with tail held", 64'(remain_len), 192);
    send_ack(32'd1024);
    tick(4);
    chk("R4 tail still held after partial ack", 64'(remain_len), 192);
    expect_seg(2048, 192, "R4"); expect_seg(2048, 192, "R5");
    send_ack(32'd2048);
    wait_drain("R5");
    chk("R6 busy until tail acked", 64'(busy), 1);
    send_ack(32'd2240);
    tick(1);
    chk("R6 busy after tail ack", 64'(busy), 0);

    // R5: no duplicate when disabled
    expect_seg(0, 512, "R3");
    start_cmd(32'd640, 16'd512, 1'b1);
    wait_drain("R3");
    expect_seg(512, 128, "R5");
    send_ack(32'd512);
    wait_drain("R5");
    tick(5);
    send_ack(32'd640);
    tick(1);
    chk("R5 done after single tail", 64'(busy), 0);

    // R9 + R2: buffer gating and start while busy
    buf_words = 16'd0;
    start_cmd(32'd1024, 16'd1024, 1'b0);
    tick(5);
    chk("R9 nothing sent on empty buffer", 64'(remain_len), 1024);
    start_cmd(32'd9984, 16'd512, 1'b0);
    tick(2);
    chk("R2 start while busy ignored", 64'(remain_len), 1024);
    buf_words = 16'd15;
    tick(5);
    chk("R9 short buffer holds segment", 64'(remain_len), 1024);
    expect_seg(0, 1024, "R9");
    buf_words = 16'd16;
    wait_drain("R9");
    send_ack(32'd1024);
    tick(1);
    chk("R6 done after gated command", 64'(busy), 0);
    buf_words = 16'hFFFF;

    // R10 + R11: window gating, out-of-range ack
    peer_win = 32'd1000;
    expect_seg(0, 512, "R10");
    start_cmd(32'd2048, 16'd512, 1'b0);
    wait_drain("R10");
    tick(5);
    chk("R10 window holds second segment", 64'(remain_len), 1536);
    send_ack(32'd4000);
    tick(5);
    chk("R11 ack beyond issue pointer ignored", 64'(remain_len), 1536);
    for (int i = 1; i < 4; i++) begin
      expect_seg(32'(i * 512), 16'd512, "R10");
      send_ack(32'(i * 512));
      wait_drain("R10");
    end
    send_ack(32'd2048);
    tick(1);
    chk("R6 done after window-paced command", 64'(busy), 0);
    peer_win = 32'hFFFF_FFFF;

    // R8: extension while busy, ignored while idle, saturation
    buf_words = 16'd0;
    start_cmd(32'd1024 + 7, 16'd512, 1'b0);
    tick(3);
    send_ext(32'd512 + 7);
    chk("R8 extension adds to total", 64'(remain_len), 1536);
    for (int i = 0; i < 3; i++) expect_seg(32'(i * 512), 16'd512, "R8");
    buf_words = 16'hFFFF;
    wait_drain("R8");
    send_ack(32'd1536);
    tick(1);
    chk("R8 done after extended total", 64'(busy), 0);
    send_ext(32'd4096);
    tick(2);
    chk("R8 extension ignored when idle", 64'(remain_len), 0);

    // R2: rejected lengths
    start_cmd(32'd4096, 16'd9024, 1'b0);
    tick(2);
    chk("R2 segment length above max rejected", 64'(busy), 0);
    start_cmd(32'd63, 16'd512, 1'b0);
    tick(2);
    chk("R2 total below 64 rejected", 64'(busy), 0);
    start_cmd(32'd4096, 16'd63, 1'b0);
    tick(2);
    chk("R2 segment length below 64 rejected", 64'(busy), 0);

    // R2 max segment, R8 saturation
    buf_words = 16'd0;
    start_cmd(32'hFFFF_F000, 16'd8960, 1'b0);
    chk("R2 max segment length accepted", 64'(busy), 1);
    send_ext(32'h0000_2000);
    chk("R8 extension saturates", 64'(remain_len), 64'hFFFF_FFC0);
    @(negedge clk); rst_n = 1'b0;
    tick(2);
    chk("R12 busy after reset", 64'(busy), 0);
    chk("R12 remain after reset", 64'(remain_len), 0);
    rst_n = 1'b1;
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule